// File: doc/BRIEF.md
# Serial Control Register Master

This block is the controller end of a serial link that configures a chain of memory devices through their control registers. A host presents a request: read or write, a 6-bit device number, a broadcast flag, a 12-bit register address and, for writes, 16 bits of data. The block then makes the serial clock from the system clock and frames the transaction on the command pin. It shifts four 16-bit packets out on the data pin of the first device in the chain.

Every transaction lasts 64 serial clock periods. The first packet is the request, which carries an opcode, the broadcast bit and the device number. The second carries the register address. A write then sends the data word, followed by an all-zero interval packet. A read sends the interval packet third. The master then releases its data driver and, during the fourth packet, shifts in the 16 bits that the chain returns. A one-cycle done pulse marks the end of the transaction, and read data is held on its own output.

Top module: `sreg_master`

## Requirements
- R1: While reset is asserted, busy, done, sck, cmd and sio_out are 0, sio_oe is 1 and rd_data is 0.
- R2: sck idles low. Once a start is accepted, sck toggles every H system clocks, where H is the half_div value sampled at acceptance (a value of 0 counts as 1). Exactly 128 sck edges (64 periods) follow, beginning with a rising edge.
- R3: Counting sck edges of a transaction from 0, cmd is 1 when sampled at edges 0 to 3 and 0 at edge 4 and every later edge. cmd is 0 while idle.
- R4: The first 16 bits sent form the request word. Bits 15:12 hold the opcode (0001 for write, 0010 for read), bit 11 holds broadcast, bits 10:5 hold the device number and bits 4:0 are 0.
- R5: The second word is the register address in bits 11:0, with bits 15:12 zero.
- R6: Words go out most significant bit first, and one bit is sent per sck period. sio_out changes only at rising sck edges, so the value a device sees at the falling edge of period j is stream bit j.
- R7: A write sends request, address, write data, then a zero interval word, and sio_oe stays 1 for the whole transaction.
- R8: A read sends request, address, then a zero interval word. It drives sio_oe to 0 from the rising edge that opens period 48 until the transaction ends. sio_oe is 0 only during reads.
- R9: During a read, sio_in is sampled at the falling edge of periods 48 to 63, most significant bit first. rd_data takes the 16 sampled bits when the read ends. It does not change at any other time, and writes leave it unchanged.
- R10: start is accepted only while busy is 0. A start raised while busy has no effect on the running transaction and begins no later one.
- R11: done is a single-cycle pulse in the system clock cycle in which the final falling sck edge occurs. busy falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | 8 | Half serial period in system clocks, sampled at start |
| start | input | 1 | Request a transaction |
| rd_req | input | 1 | 1 = read, 0 = write |
| dev_id | input | 6 | Target device number |
| bcast | input | 1 | Address every device in the chain |
| reg_addr | input | 12 | Control register address |
| wr_data | input | 16 | Data word for writes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read back |
| sck | output | 1 | Serial clock to all devices |
| cmd | output | 1 | Framing/command pin |
| sio_out | output | 1 | Serial data toward the chain |
| sio_oe | output | 1 | Output enable for sio_out |
| sio_in | input | 1 | Serial data returned from the chain |

## Verification
A wrong edge counter appears as a cmd or data bit at the wrong sck edge. It also shows as a transaction that does not end after exactly 128 edges, and a device model sampling each edge sees this within the first packet. A stale or wrong copy of the request appears in the first 48 bits at the pins. A wrong turnaround shows up in sio_oe at the start of period 48 and in rd_data as soon as done pulses. An accepted start while busy would corrupt the stream bits captured during that transaction, or it would raise busy again after done.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int WORD_W      = 16;
  localparam int N_WORDS     = 4;
  localparam int DEV_W       = 6;
  localparam int ADDR_W      = 12;
  localparam int STREAM_BITS = WORD_W * N_WORDS;
  localparam int N_EDGES     = 2 * STREAM_BITS;
  localparam int EDGE_W      = $clog2(N_EDGES);
  localparam int PTR_W       = EDGE_W - 1;

  localparam logic [EDGE_W-1:0] CMD_HIGH_EDGES = EDGE_W'(4);
  localparam logic [EDGE_W-1:0] RX_FIRST_EDGE  = EDGE_W'(2 * WORD_W * (N_WORDS - 1));

  localparam logic [3:0] OPC_WRITE = 4'b0001;
  localparam logic [3:0] OPC_READ  = 4'b0010;

  typedef struct packed {
    logic              rd;
    logic              bcast;
    logic [DEV_W-1:0]  dev;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
  } sreq_t;

  function automatic logic [WORD_W-1:0] request_word(sreq_t r);
    return {(r.rd ? OPC_READ : OPC_WRITE), r.bcast, r.dev, 5'b00000};
  endfunction

  function automatic logic [WORD_W-1:0] address_word(sreq_t r);
    return {{(WORD_W-ADDR_W){1'b0}}, r.addr};
  endfunction

  function automatic logic [STREAM_BITS-1:0] build_stream(sreq_t r);
    logic [WORD_W-1:0] third;
    third = r.rd ? '0 : r.wdata;
    return {request_word(r), address_word(r), third, {WORD_W{1'b0}}};
  endfunction

  function automatic logic cmd_level(logic [EDGE_W-1:0] edge_no);
    return edge_no < CMD_HIGH_EDGES;
  endfunction
endpackage

// File: rtl/sreg_sclk.sv
module sreg_sclk
  import sreg_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [HALF_W-1:0] half_div,
  output logic              sck,
  output logic              edge_ev,
  output logic [EDGE_W-1:0] edge_idx,
  output logic              last_edge
);
  logic [HALF_W-1:0] hcnt;
  logic [HALF_W-1:0] hlim_q;

  assign edge_ev   = run && (hcnt == hlim_q - 1'b1);
  assign last_edge = edge_ev && (edge_idx == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt     <= '0;
      hlim_q   <= HALF_W'(1);
      sck      <= 1'b0;
      edge_idx <= '0;
    end else if (load) begin
      hcnt     <= '0;
      hlim_q   <= (half_div == '0) ? HALF_W'(1) : half_div;
      sck      <= 1'b0;
      edge_idx <= '0;
    end else if (edge_ev) begin
      hcnt     <= '0;
      sck      <= ~sck;
      edge_idx <= edge_idx + 1'b1;
    end else if (run) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R2
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck);

  // R2
  sck_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (sck == edge_idx[0]));
endmodule

// File: rtl/sreg_txpath.sv
module sreg_txpath
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  sreq_t             req_in,
  input  logic              edge_ev,
  input  logic [EDGE_W-1:0] edge_idx,
  input  logic              last_edge,
  output logic              sio_out,
  output logic              sio_oe,
  output logic              cmd,
  output logic              is_read
);
  logic [STREAM_BITS-1:0] stream;
  logic [STREAM_BITS-1:0] next_stream;
  logic [PTR_W-1:0]       bit_ptr;
  logic                   rising_ev;
  logic                   in_rx_word;

  assign next_stream = build_stream(req_in);
  // bit j of the period sits at stream[STREAM_BITS-1-j]
  assign bit_ptr     = ~edge_idx[EDGE_W-1:1];
  assign rising_ev   = edge_ev && !edge_idx[0];
  assign in_rx_word  = edge_idx >= RX_FIRST_EDGE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stream  <= '0;
      is_read <= 1'b0;
      sio_out <= 1'b0;
      sio_oe  <= 1'b1;
      cmd     <= 1'b0;
    end else if (load) begin
      stream  <= next_stream;
      is_read <= req_in.rd;
      sio_out <= next_stream[STREAM_BITS-1];
      sio_oe  <= 1'b1;
      cmd     <= 1'b1;
    end else if (last_edge) begin
      sio_out <= 1'b0;
      sio_oe  <= 1'b1;
      cmd     <= 1'b0;
    end else if (edge_ev) begin
      cmd <= cmd_level(edge_idx + 1'b1);
      if (rising_ev) begin
        if (is_read && in_rx_word) begin
          sio_oe  <= 1'b0;
          sio_out <= 1'b0;
        end else begin
          sio_out <= stream[bit_ptr];
        end
      end
    end
  end

  // R8
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sio_oe |-> is_read);

  // R3
  cmd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |-> (edge_idx < CMD_HIGH_EDGES));
endmodule

// File: rtl/sreg_rxpath.sv
module sreg_rxpath
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_ev,
  input  logic [EDGE_W-1:0] edge_idx,
  input  logic              last_edge,
  input  logic              rd_active,
  input  logic              sio_in,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-2:0] shreg;
  logic              cap;

  assign cap = edge_ev && rd_active && edge_idx[0] && (edge_idx > RX_FIRST_EDGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      rd_data <= '0;
    end else if (cap && last_edge) begin
      rd_data <= {shreg, sio_in};
    end else if (cap) begin
      shreg <= {shreg[WORD_W-3:0], sio_in};
    end
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_edge |=> $stable(rd_data));
endmodule

// File: rtl/sreg_master.sv
module sreg_master
  import sreg_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_div,
  input  logic              start,
  input  logic              rd_req,
  input  logic [5:0]        dev_id,
  input  logic              bcast,
  input  logic [11:0]       reg_addr,
  input  logic [15:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic              sck,
  output logic              cmd,
  output logic              sio_out,
  output logic              sio_oe,
  input  logic              sio_in
);
  logic              accept;
  logic              edge_ev;
  logic              last_edge;
  logic              is_read;
  logic [EDGE_W-1:0] edge_idx;
  sreq_t             req_in;

  assign accept = start && !busy;
  assign req_in = '{rd: rd_req, bcast: bcast, dev: dev_id, addr: reg_addr, wdata: wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= last_edge;
      if (accept)         busy <= 1'b1;
      else if (last_edge) busy <= 1'b0;
    end
  end

  sreg_sclk #(.HALF_W(HALF_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(busy), .half_div(half_div),
    .sck(sck), .edge_ev(edge_ev), .edge_idx(edge_idx), .last_edge(last_edge)
  );

  sreg_txpath u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .req_in(req_in),
    .edge_ev(edge_ev), .edge_idx(edge_idx), .last_edge(last_edge),
    .sio_out(sio_out), .sio_oe(sio_oe), .cmd(cmd), .is_read(is_read)
  );

  sreg_rxpath u_rx (
    .clk(clk), .rst_n(rst_n), .edge_ev(edge_ev), .edge_idx(edge_idx),
    .last_edge(last_edge), .rd_active(is_read), .sio_in(sio_in), .rd_data(rd_data)
  );

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> (busy || done));
endmodule

// File: tb/tb_sreg_master.sv
module tb_sreg_master;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  half_div = 8'd2;
  logic        start = 1'b0, rd_req = 1'b0, bcast = 1'b0;
  logic [5:0]  dev_id = '0;
  logic [11:0] reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy, done, sck, cmd, sio_out, sio_oe;
  logic        sio_in = 1'b0;
  logic [15:0] rd_data;

  sreg_master dut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .start(start), .rd_req(rd_req),
    .dev_id(dev_id), .bcast(bcast), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .sck(sck), .cmd(cmd),
    .sio_out(sio_out), .sio_oe(sio_oe), .sio_in(sio_in)
  );

  int n_tests = 0, n_fail = 0;
  int cur_h = 1;
  logic [15:0] resp = '0;
  logic [15:0] last_rd = '0;

  // device-side monitor state
  logic sck_p = 0, cmd_p = 0, out_p = 0, oe_p = 1, busy_p = 0;
  int edges = 0, gap = 0, gap_err = 0, done_cnt = 0, done_at_end = 0, fall_err = 0, idle_err = 0;
  logic [127:0] cmd_rec = '0;
  logic [63:0]  bit_rec = '0, oe_rec = '0;

  always @(negedge clk) begin
    if (busy && !busy_p) begin
      gap = 0; edges = 0; gap_err = 0; done_cnt = 0; done_at_end = 0; fall_err = 0;
      cmd_rec = '0; bit_rec = '0; oe_rec = '0;
    end else if (busy || busy_p) begin
      gap++;
    end
    if ((busy || busy_p) && sck !== sck_p) begin
      if (gap != cur_h) gap_err++;
      gap = 0;
      if (edges < 128) begin
        cmd_rec[edges] = cmd_p;
        if (edges % 2 == 1) begin
          bit_rec[63 - edges/2] = out_p;
          oe_rec[63 - edges/2]  = oe_p;
          if (edges != 127 && sio_out !== out_p) fall_err++;
        end
      end
      if (sck && edges/2 >= 48) sio_in = resp[15 - (edges/2 - 48)];
      if (edges == 127 && done) done_at_end++;
      edges++;
    end
    if (!busy && !busy_p) begin
      sio_in = 1'b0;
      if (rst_n && (cmd || sck)) idle_err++;
    end
    if (done) done_cnt++;
    sck_p = sck; cmd_p = cmd; out_p = sio_out; oe_p = sio_oe; busy_p = busy;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    // R1 reset values
    check(busy === 0 && done === 0, "R1 busy/done", {busy, done}, 0);
    check(sck === 0 && cmd === 0 && sio_out === 0, "R1 sck/cmd/out", {sck, cmd, sio_out}, 0);
    check(sio_oe === 1, "R1 oe", sio_oe, 1);
    check(rd_data === 16'h0, "R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_txn(input string name, input logic [7:0] h, input bit rd,
                       input logic [5:0] dv, input bit bc, input logic [11:0] ad,
                       input logic [15:0] wd, input logic [15:0] rsp, input bit poke);
    logic [63:0] exp;
    logic [63:0] exp_oe;
    exp = '0;
    exp[63:60] = rd ? 4'b0010 : 4'b0001;
    exp[59]    = bc;
    exp[58:53] = dv;
    exp[43:32] = ad;
    if (!rd) exp[31:16] = wd;
    exp_oe = rd ? {{48{1'b1}}, 16'h0} : {64{1'b1}};
    half_div = h;
    cur_h = (h == 0) ? 1 : int'(h);
    resp = rsp;
    @(negedge clk);
    rd_req = rd; dev_id = dv; bcast = bc; reg_addr = ad; wr_data = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      rd_req = ~rd; dev_id = ~dv; reg_addr = ~ad; wr_data = ~wd; half_div = h + 8'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    if (rd) last_rd = rsp;
    // R2 edge count and spacing
    check(edges == 128, {"R2 edge count ", name}, edges, 128);
    check(gap_err == 0, {"R2 half period ", name}, gap_err, 0);
    // R3 framing on cmd
    check(cmd_rec == 128'hF, {"R3 cmd per edge ", name}, cmd_rec[63:0], 64'hF);
    // R4 request word
    check(bit_rec[63:48] == exp[63:48], {"R4 request word ", name}, bit_rec[63:48], exp[63:48]);
    // R5 address word
    check(bit_rec[47:32] == exp[47:32], {"R5 address word ", name}, bit_rec[47:32], exp[47:32]);
    // R6 no change at falling edges
    check(fall_err == 0, {"R6 out changed at fall ", name}, fall_err, 0);
    if (rd) begin
      // R8 read order and turnaround
      check(bit_rec[31:16] == 16'h0, {"R8 interval word ", name}, bit_rec[31:16], 0);
      check(oe_rec == exp_oe, {"R8 oe pattern ", name}, oe_rec, exp_oe);
    end else begin
      // R7 write order and oe
      check(bit_rec[31:0] == exp[31:0], {"R7 data+interval ", name}, bit_rec[31:0], exp[31:0]);
      check(oe_rec == exp_oe, {"R7 oe pattern ", name}, oe_rec, exp_oe);
    end
    // R9 read data
    check(rd_data === last_rd, {"R9 rd_data ", name}, rd_data, last_rd);
    // R11 done timing
    check(done_cnt == 1 && done_at_end == 1, {"R11 done pulse ", name}, done_cnt * 16 + done_at_end, 17);
    repeat (6) @(negedge clk);
    // R10 no extra transaction
    check(busy === 0 && edges == 128, {"R10 stays idle ", name}, edges, 128);
    check(idle_err == 0, {"R3 idle cmd/sck ", name}, idle_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_txn("wr_h2",      8'd2, 1'b0, 6'h2A, 1'b0, 12'hABC, 16'h1234, 16'h0000, 1'b0);
    t_txn("rd_h3",      8'd3, 1'b1, 6'h15, 1'b1, 12'h5A5, 16'h0000, 16'hC3A5, 1'b0);
    t_txn("wr_h1_ones", 8'd1, 1'b0, 6'h3F, 1'b1, 12'hFFF, 16'hFFFF, 16'h0000, 1'b0);
    t_txn("rd_h0",      8'd0, 1'b1, 6'h01, 1'b0, 12'h001, 16'h0000, 16'h8001, 1'b0);
    t_txn("wr_poke",    8'd2, 1'b0, 6'h0C, 1'b0, 12'h3C3, 16'hA55A, 16'h0000, 1'b1);
    t_txn("rd_poke",    8'd1, 1'b1, 6'h33, 1'b1, 12'h800, 16'h0000, 16'h7FFE, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule